// File: doc/BRIEF.md
# Mixed-Width ALU with Condition Flags

This unit is the arithmetic core of a small register machine with 12-bit registers. It combines a 12-bit left operand with an 8-bit right operand. A 2-bit operation code selects one of four operations: bitwise AND, bitwise XOR, addition or subtraction. The bitwise operations change only the low byte and leave the top nibble of the left operand as it is. Addition and subtraction carry or borrow through all twelve bits. The result is combinational.

A registered pair of flags, negative and zero, records the sign and zero state of the last result that the caller chose to commit with a write enable. A condition evaluator compares the held flags against a selected branch condition. An increment request makes the unit add one to the left operand without touching the flags. This serves program-counter advances and pointer bumps that must not disturb a pending branch decision.

Top module: `mw_alu`

## Requirements
- R1: With `op` = 2'b00 (AND) and `inc` low, `result[7:0]` is `lhs[7:0] & rhs` and `result[11:8]` equals `lhs[11:8]`.
- R2: With `op` = 2'b01 (XOR) and `inc` low, `result[7:0]` is `lhs[7:0] ^ rhs` and `result[11:8]` equals `lhs[11:8]`.
- R3: With `op` = 2'b10 (ADD) and `inc` low, `result` is `lhs` plus the zero-extended `rhs`, modulo 4096. A carry out of bit 7 reaches the upper nibble.
- R4: With `op` = 2'b11 (SUB) and `inc` low, `result` is `lhs` minus the zero-extended `rhs`, modulo 4096. A borrow out of bit 7 reaches the upper nibble.
- R5: While `inc` is high, `result` is `lhs + 1` modulo 4096, whatever `op` and `rhs` are.
- R6: On a rising clock edge with `flag_we` high and `inc` low, `flag_n` takes `result[11]` and `flag_z` is set exactly when `result` is zero.
- R7: On a rising clock edge with `flag_we` low, both flags keep their values.
- R8: On a rising clock edge with `inc` high, both flags keep their values, even when `flag_we` is high.
- R9: A rising clock edge with `rst` high clears both flags.
- R10: `cond_true` depends only on the held flags and `cond_sel`. Code 2'b00 gives `flag_z`. Code 2'b01 gives `!flag_z`. Code 2'b10 gives `!flag_n && !flag_z`. Code 2'b11 gives `flag_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the flags |
| op | input | 2 | Operation code: 00 AND, 01 XOR, 10 ADD, 11 SUB |
| lhs | input | 12 | Left operand |
| rhs | input | 8 | Right operand |
| inc | input | 1 | Increment request: forces lhs+1 and blocks flag writes |
| flag_we | input | 1 | Commit the current result to the flags at the next edge |
| cond_sel | input | 2 | Branch condition: 00 zero, 01 not zero, 10 positive, 11 negative |
| result | output | 12 | Combinational result |
| flag_n | output | 1 | Held negative flag |
| flag_z | output | 1 | Held zero flag |
| cond_true | output | 1 | Selected condition holds on the held flags |

## Verification
An increment request and a flag commit can arrive in the same cycle. That happens when the increment of an instruction overlaps the write-back of an arithmetic result. The bench first leaves the flags in the positive state. It then drives `inc` and `flag_we` high together with `lhs` = 12'hFFF. The wrapped result of zero would set the zero flag if it were committed. The check requires `result` to read 12'h000 in that cycle, and requires both flags and the positive condition to be unchanged after the edge.

// File: rtl/mw_alu_pkg.sv
package mw_alu_pkg;

    typedef enum logic [1:0] {
        OP_AND = 2'b00,
        OP_XOR = 2'b01,
        OP_ADD = 2'b10,
        OP_SUB = 2'b11
    } alu_op_e;

    typedef enum logic [1:0] {
        CC_ZERO    = 2'b00,
        CC_NONZERO = 2'b01,
        CC_POS     = 2'b10,
        CC_NEG     = 2'b11
    } cond_e;

    typedef struct packed {
        logic neg;
        logic zero;
    } flags_t;

endpackage

// File: rtl/mw_alu_datapath.sv
module mw_alu_datapath
    import mw_alu_pkg::*;
#(
    parameter int unsigned WORD_W = 12,
    parameter int unsigned BYTE_W = 8
) (
    input  alu_op_e           op,
    input  logic [WORD_W-1:0] lhs,
    input  logic [BYTE_W-1:0] rhs,
    input  logic              inc,
    output logic [WORD_W-1:0] result
);

    localparam int unsigned UPPER_W = WORD_W - BYTE_W;

    alu_op_e           eff_op;
    logic [BYTE_W-1:0] eff_rhs;
    logic [WORD_W-1:0] rhs_ext;
    logic [WORD_W-1:0] logic_res;
    logic [WORD_W-1:0] sum_res;
    logic [WORD_W-1:0] diff_res;

    // An increment request is an ADD of one.
    always_comb begin
        eff_op  = inc ? OP_ADD : op;
        eff_rhs = inc ? BYTE_W'(1) : rhs;
        rhs_ext = {{UPPER_W{1'b0}}, eff_rhs};
    end

    // Bitwise slice: the low byte combines, the upper bits pass through.
    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
        if (i < BYTE_W) begin : g_mix
            assign logic_res[i] = (eff_op == OP_AND) ? (lhs[i] & eff_rhs[i])
                                                     : (lhs[i] ^ eff_rhs[i]);
        end else begin : g_pass
            assign logic_res[i] = lhs[i];
        end
    end

    always_comb begin
        sum_res  = lhs + rhs_ext;
        diff_res = lhs - rhs_ext;
        unique case (eff_op)
            OP_AND, OP_XOR: result = logic_res;
            OP_ADD:         result = sum_res;
            OP_SUB:         result = diff_res;
            default:        result = logic_res;
        endcase
    end

endmodule

// File: rtl/mw_alu_flags.sv
module mw_alu_flags
    import mw_alu_pkg::*;
#(
    parameter int unsigned WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic [WORD_W-1:0] result,
    output flags_t            flags
);

    flags_t flg_d;
    flags_t flg_q;

    always_comb begin
        flg_d = flg_q;
        if (commit) begin
            flg_d.neg  = result[WORD_W-1];
            flg_d.zero = ~|result;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flg_q <= '0;
        end else begin
            flg_q <= flg_d;
        end
    end

    assign flags = flg_q;

endmodule

// File: rtl/mw_alu_cond.sv
module mw_alu_cond
    import mw_alu_pkg::*;
(
    input  cond_e  sel,
    input  flags_t flags,
    output logic   hit
);

    always_comb begin
        unique case (sel)
            CC_ZERO:    hit = flags.zero;
            CC_NONZERO: hit = ~flags.zero;
            CC_POS:     hit = ~flags.neg & ~flags.zero;
            CC_NEG:     hit = flags.neg;
            default:    hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/mw_alu.sv
module mw_alu
    import mw_alu_pkg::*;
#(
    parameter int unsigned WORD_W = 12,
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        op,
    input  logic [WORD_W-1:0] lhs,
    input  logic [BYTE_W-1:0] rhs,
    input  logic              inc,
    input  logic              flag_we,
    input  logic [1:0]        cond_sel,
    output logic [WORD_W-1:0] result,
    output logic              flag_n,
    output logic              flag_z,
    output logic              cond_true
);

    flags_t flags;
    logic   commit;

    // Internal increments never write the flags.
    assign commit = flag_we & ~inc;

    mw_alu_datapath #(
        .WORD_W (WORD_W),
        .BYTE_W (BYTE_W)
    ) u_dp (
        .op     (alu_op_e'(op)),
        .lhs    (lhs),
        .rhs    (rhs),
        .inc    (inc),
        .result (result)
    );

    mw_alu_flags #(
        .WORD_W (WORD_W)
    ) u_flags (
        .clk    (clk),
        .rst    (rst),
        .commit (commit),
        .result (result),
        .flags  (flags)
    );

    mw_alu_cond u_cond (
        .sel   (cond_e'(cond_sel)),
        .flags (flags),
        .hit   (cond_true)
    );

    assign flag_n = flags.neg;
    assign flag_z = flags.zero;

endmodule

// File: rtl/mw_alu_chk.sv
module mw_alu_chk #(
    parameter int unsigned WORD_W = 12,
    parameter int unsigned BYTE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        op,
    input logic [WORD_W-1:0] lhs,
    input logic [BYTE_W-1:0] rhs,
    input logic              inc,
    input logic              flag_we,
    input logic [1:0]        cond_sel,
    input logic [WORD_W-1:0] result,
    input logic              flag_n,
    input logic              flag_z,
    input logic              cond_true
);

    localparam int unsigned UPPER_W = WORD_W - BYTE_W;

    AST_LOGIC_UPPER: assert property (@(posedge clk) disable iff (rst)
        (!inc && !op[1]) |-> (result[WORD_W-1:BYTE_W] == lhs[WORD_W-1:BYTE_W])); // R1

    AST_XOR_LOW: assert property (@(posedge clk) disable iff (rst)
        (!inc && op == 2'b01) |-> (result[BYTE_W-1:0] == (lhs[BYTE_W-1:0] ^ rhs))); // R2

    AST_ADD_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!inc && op == 2'b10) |-> (result == WORD_W'(lhs + {{UPPER_W{1'b0}}, rhs}))); // R3

    AST_INC_SUM: assert property (@(posedge clk) disable iff (rst)
        inc |-> (result == WORD_W'(lhs + 1'b1))); // R5

    AST_FLAG_UPDATE: assert property (@(posedge clk) disable iff (rst)
        (flag_we && !inc) |=> (flag_n == $past(result[WORD_W-1]) && flag_z == ($past(result) == '0))); // R6

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !flag_we |=> ($stable(flag_n) && $stable(flag_z))); // R7

    AST_INC_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        inc |=> ($stable(flag_n) && $stable(flag_z))); // R8

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!flag_n && !flag_z)); // R9

    AST_COND_NEG: assert property (@(posedge clk) disable iff (rst)
        (cond_sel == 2'b11) |-> (cond_true == flag_n)); // R10

endmodule

bind mw_alu mw_alu_chk #(
    .WORD_W (WORD_W),
    .BYTE_W (BYTE_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .op        (op),
    .lhs       (lhs),
    .rhs       (rhs),
    .inc       (inc),
    .flag_we   (flag_we),
    .cond_sel  (cond_sel),
    .result    (result),
    .flag_n    (flag_n),
    .flag_z    (flag_z),
    .cond_true (cond_true)
);

// File: tb/mw_alu_tb.sv
module mw_alu_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 5000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  op = 2'b00;
    logic [11:0] lhs = '0;
    logic [7:0]  rhs = '0;
    logic        inc = 1'b0;
    logic        flag_we = 1'b0;
    logic [1:0]  cond_sel = 2'b00;
    logic [11:0] result;
    logic        flag_n;
    logic        flag_z;
    logic        cond_true;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mw_alu u_dut (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .lhs       (lhs),
        .rhs       (rhs),
        .inc       (inc),
        .flag_we   (flag_we),
        .cond_sel  (cond_sel),
        .result    (result),
        .flag_n    (flag_n),
        .flag_z    (flag_z),
        .cond_true (cond_true)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive the inputs at a falling edge and let the combinational path settle.
    task automatic drive(input logic [1:0] o, input logic [11:0] a, input logic [7:0] b,
                         input logic i, input logic we);
        @(negedge clk);
        op = o; lhs = a; rhs = b; inc = i; flag_we = we;
        #1;
    endtask

    // Let one rising edge pass, then return to the quiet half of the cycle.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        flag_we = 1'b0; inc = 1'b0;
        #1;
    endtask

    task automatic cond_is(input string req, input logic [1:0] sel, input logic exp);
        cond_sel = sel;
        #1;
        check(req, cond_true, exp);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R9 flag_n after reset", flag_n, 0);
        check("R9 flag_z after reset", flag_z, 0);
        cond_is("R10 zero cond after reset", 2'b00, 1'b0);
        cond_is("R10 nonzero cond after reset", 2'b01, 1'b1);
        rst = 1'b0;
    endtask

    task automatic t_logic();
        drive(2'b00, 12'hABC, 8'h0F, 1'b0, 1'b0);
        check("R1 AND upper kept", result, 12'hA0C);
        drive(2'b00, 12'h3F0, 8'hFF, 1'b0, 1'b0);
        check("R1 AND all ones", result, 12'h3F0);
        drive(2'b01, 12'h5F0, 8'hFF, 1'b0, 1'b0);
        check("R2 XOR upper kept", result, 12'h50F);
        drive(2'b01, 12'hFAA, 8'hAA, 1'b0, 1'b0);
        check("R2 XOR low to zero", result, 12'hF00);
    endtask

    task automatic t_arith();
        drive(2'b10, 12'h0FF, 8'h01, 1'b0, 1'b0);
        check("R3 ADD carry into upper", result, 12'h100);
        drive(2'b10, 12'hFFF, 8'h01, 1'b0, 1'b0);
        check("R3 ADD wrap", result, 12'h000);
        drive(2'b10, 12'h123, 8'hFF, 1'b0, 1'b0);
        check("R3 ADD full byte", result, 12'h222);
        drive(2'b11, 12'h100, 8'h01, 1'b0, 1'b0);
        check("R4 SUB borrow from upper", result, 12'h0FF);
        drive(2'b11, 12'h000, 8'h01, 1'b0, 1'b0);
        check("R4 SUB wrap", result, 12'hFFF);
        drive(2'b11, 12'h800, 8'h80, 1'b0, 1'b0);
        check("R4 SUB mid", result, 12'h780);
    endtask

    task automatic t_inc();
        drive(2'b00, 12'h7FF, 8'h55, 1'b1, 1'b0);
        check("R5 inc overrides AND", result, 12'h800);
        drive(2'b11, 12'hFFF, 8'h33, 1'b1, 1'b0);
        check("R5 inc wraps", result, 12'h000);
    endtask

    task automatic t_flags();
        drive(2'b11, 12'h000, 8'h01, 1'b0, 1'b1);
        step();
        check("R6 negative flag set", flag_n, 1);
        check("R6 zero flag clear", flag_z, 0);
        cond_is("R10 negative cond", 2'b11, 1'b1);
        cond_is("R10 positive cond false", 2'b10, 1'b0);
        drive(2'b10, 12'hFFF, 8'h01, 1'b0, 1'b1);
        step();
        check("R6 zero flag set", flag_z, 1);
        check("R6 negative flag clear", flag_n, 0);
        cond_is("R10 zero cond", 2'b00, 1'b1);
        cond_is("R10 nonzero cond false", 2'b01, 1'b0);
        drive(2'b01, 12'h010, 8'h05, 1'b0, 1'b0);
        step();
        check("R7 zero flag held", flag_z, 1);
        check("R7 negative flag held", flag_n, 0);
        drive(2'b10, 12'h010, 8'h05, 1'b0, 1'b1);
        step();
        cond_is("R10 positive cond", 2'b10, 1'b1);
        cond_is("R10 negative cond false", 2'b11, 1'b0);
    endtask

    task automatic t_collide();
        // Flags are positive here; an increment to zero with flag_we must not commit.
        drive(2'b00, 12'hFFF, 8'h00, 1'b1, 1'b1);
        check("R5 inc result during flag_we", result, 12'h000);
        step();
        check("R8 zero flag untouched by inc", flag_z, 0);
        check("R8 negative flag untouched by inc", flag_n, 0);
        cond_is("R8 positive cond survives inc", 2'b10, 1'b1);
    endtask

    task automatic t_mid_reset();
        drive(2'b11, 12'h000, 8'h02, 1'b0, 1'b1);
        step();
        check("R6 negative before reset", flag_n, 1);
        rst = 1'b1;
        step();
        rst = 1'b0;
        check("R9 negative cleared", flag_n, 0);
        check("R9 zero cleared", flag_z, 0);
    endtask

    initial begin
        t_reset();
        t_logic();
        t_arith();
        t_inc();
        t_flags();
        t_collide();
        t_mid_reset();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < WATCHDOG_CYCLES && !done; c++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule